// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block holds a set of independent down-counting interval timers behind a small synchronous register bus. Software gives each channel an interval and a control word, and the channel then counts down one step per clock. When a channel reaches the end of its interval it raises a sticky interrupt flag. A channel in repeat mode then reloads and keeps running. A channel in one-shot mode stops and becomes idle.

Interval writes come in two kinds, chosen by bit 31 of the written word. An immediate write replaces the live count on the next edge. A deferred write only replaces the stored interval, which the channel uses at its next reload. A deferred write to an idle channel still starts that channel at once.

Two shared registers sit above the channels. The first reports the lowest-numbered idle channel, which lets software allocate a free timer. The second gathers every channel's flag and clears any subset of them in one write. A single interrupt line is driven from the flags whose channel has its enable set.

Top module: `interval_timer_bank`

## Requirements
- R1: After reset, every channel register reads 0, the idle register reads 0x00 (channel 0 is idle), the flag register reads 0 and `irqOut` is low.
- R2: Registers are word addressed. Channel n occupies byte offsets 16n to 16n+15: the interval at +0, the live count at +4, control at +8 and status at +12. The idle register is at 0xF4 and the flag register at 0xF8. Offset 0xF0 and every other unmapped offset read 0. Reads have no side effects.
- R3: An interval write with bit 31 = 1 stores bits 30:0 as the interval and places them in the count on the same clock edge. This holds whether or not the channel is running.
- R4: An interval write with bit 31 = 0 to a running channel changes only the stored interval (read back at +0). The count keeps decrementing, and the new value is used at the next reload. The same write to an idle channel loads the count at once.
- R5: A channel with a nonzero count decrements it by one every clock. The count is read at +4, and writes to +4 have no effect.
- R6: When a count of 1 steps on, status bit 0 (the flag) becomes 1. Status bit 1 reads 1 exactly while the count is nonzero.
- R7: Control bits 2:1 hold the mode. Value 1 is one-shot: at expiry the count becomes 0. Every other value repeats: at expiry the count reloads the stored interval, and a stored interval of 0 leaves the channel stopped.
- R8: Control bit 0 is the interrupt enable. Control bits 2:0 read back as written, and bits 31:3 read 0.
- R9: Writing an interval of 0 immediately (bit 31 = 1), or to an idle channel, leaves the count at 0 and the channel idle.
- R10: The idle register holds the index of the lowest channel whose count is 0 in bits 7:4, with all other bits 0. When every channel is running it reads 0x40.
- R11: Bit n of the flag register mirrors channel n's flag. Writing the flag register clears each flag whose mask bit is 1. Writing status with bit 0 = 1 clears that channel's flag.
- R12: `irqOut` is 1 exactly when some channel has both its flag and its enable set.
- R13: If an expiry and a clear of the same flag fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write enable, sampled at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Read data and `irqOut` are combinational from state. They reflect a write, a decrement or an expiry in the cycle after the edge that caused it, so every register effect appears exactly one cycle after its stimulus. The bench runs a behavioural model that advances once per rising edge, using the bus values that were applied before that edge. It compares `busRdata` and `irqOut` with the model shortly after each falling edge, once the new address has settled. The tests place deferred and immediate loads, clears and expiries on chosen edges to reach the same-edge cases. The run ends with a long random stretch.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Word offsets inside one channel's 16-byte window
  localparam logic [1:0] REG_IVAL  = 2'd0;
  localparam logic [1:0] REG_TIMER = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  // Word addresses (byte address >> 2) of the shared registers
  localparam logic [5:0] WA_MODECFG = 6'h3C;
  localparam logic [5:0] WA_IDLE    = 6'h3D;
  localparam logic [5:0] WA_FLAGS   = 6'h3E;

  typedef enum logic [1:0] {
    MODE_REPEAT  = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_RSV2    = 2'd2,
    MODE_RSV3    = 2'd3
  } tmrMode_t;

  // Per-channel strobes from the bus decoder to the counters
  typedef struct packed {
    logic wrIval;
    logic loadNow;
    logic wrCtrl;
    logic clrFlag;
  } chStrobe_t;

endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IVAL_W = 31
) (
  input  logic [7:0]                          busAddr,
  input  logic                                busWe,
  input  logic [31:0]                         busWdata,
  input  logic [NUM_CH-1:0][IVAL_W-1:0]       chCount,
  input  logic [NUM_CH-1:0][IVAL_W-1:0]       chIval,
  input  logic [NUM_CH-1:0]                   chFlag,
  input  logic [NUM_CH-1:0]                   chIen,
  input  logic [NUM_CH-1:0][1:0]              chMode,
  output chStrobe_t [NUM_CH-1:0]              strobes,
  output logic [IVAL_W-1:0]                   wrVal,
  output logic [31:0]                         busRdata,
  output logic                                irqOut
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int IDLE_W = 4;

  logic [5:0]        wordAddr;
  logic [1:0]        wordSel;
  logic [CH_W-1:0]   chIdx;
  logic              inChRegion;
  logic              flagsWrite;
  logic [IDLE_W-1:0] idleIdx;
  logic [1:0]        unusedAddrBits;

  assign wordAddr       = busAddr[7:2];
  assign wordSel        = busAddr[3:2];
  assign chIdx          = busAddr[4 +: CH_W];
  assign inChRegion     = wordAddr < 6'(NUM_CH * 4);
  assign flagsWrite     = busWe && (wordAddr == WA_FLAGS);
  assign wrVal          = busWdata[IVAL_W-1:0];
  assign unusedAddrBits = busAddr[1:0];

  // Write decode: one strobe set per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic chHit;
    assign chHit = busWe && inChRegion && (chIdx == CH_W'(c));
    assign strobes[c].wrIval  = chHit && (wordSel == REG_IVAL);
    assign strobes[c].loadNow = busWdata[31];
    assign strobes[c].wrCtrl  = chHit && (wordSel == REG_CTRL);
    assign strobes[c].clrFlag = (chHit && (wordSel == REG_STAT) && busWdata[0])
                              || (flagsWrite && busWdata[c]);
  end

  // Lowest idle channel, NUM_CH when none is idle
  always_comb begin
    idleIdx = IDLE_W'(NUM_CH);
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chCount[i] == '0) idleIdx = IDLE_W'(i);
    end
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    if (inChRegion) begin
      case (wordSel)
        REG_IVAL:  busRdata = 32'(chIval[chIdx]);
        REG_TIMER: busRdata = 32'(chCount[chIdx]);
        REG_CTRL:  busRdata = {29'b0, chMode[chIdx], chIen[chIdx]};
        default:   busRdata = {30'b0, chCount[chIdx] != '0, chFlag[chIdx]};
      endcase
    end else if (wordAddr == WA_IDLE) begin
      busRdata = {24'b0, idleIdx, 4'b0};
    end else if (wordAddr == WA_FLAGS) begin
      busRdata = 32'(chFlag);
    end else if (wordAddr == WA_MODECFG) begin
      busRdata = '0;
    end
  end

  assign irqOut = |(chFlag & chIen);

endmodule

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IVAL_W = 31
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chStrobe_t [NUM_CH-1:0]        strobes,
  input  logic [IVAL_W-1:0]             wrVal,
  output logic [NUM_CH-1:0][IVAL_W-1:0] chCount,
  output logic [NUM_CH-1:0][IVAL_W-1:0] chIval,
  output logic [NUM_CH-1:0]             chFlag,
  output logic [NUM_CH-1:0]             chIen,
  output logic [NUM_CH-1:0][1:0]        chMode
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [IVAL_W-1:0] cnt;
    logic [IVAL_W-1:0] ival;
    logic              flag;
    logic              ien;
    tmrMode_t          mode;
    logic              expire;
    logic              oneShot;
    logic              takeNew;

    assign expire  = (cnt == IVAL_W'(1));
    assign oneShot = (mode == MODE_ONESHOT);
    assign takeNew = strobes[c].wrIval && (strobes[c].loadNow || cnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        ival <= '0;
        flag <= 1'b0;
        ien  <= 1'b0;
        mode <= MODE_REPEAT;
      end else begin
        if (takeNew)           cnt <= wrVal;
        else if (expire)       cnt <= oneShot ? '0 : ival;
        else if (cnt != '0)    cnt <= cnt - IVAL_W'(1);

        if (strobes[c].wrIval) ival <= wrVal;

        if (expire)                  flag <= 1'b1;
        else if (strobes[c].clrFlag) flag <= 1'b0;

        if (strobes[c].wrCtrl) begin
          ien  <= wrVal[0];
          mode <= tmrMode_t'(wrVal[2:1]);
        end
      end
    end

    assign chCount[c] = cnt;
    assign chIval[c]  = ival;
    assign chFlag[c]  = flag;
    assign chIen[c]   = ien;
    assign chMode[c]  = mode;
  end

endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IVAL_W = 31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqOut
);

  chStrobe_t [NUM_CH-1:0]        strobes;
  logic [IVAL_W-1:0]             wrVal;
  logic [NUM_CH-1:0][IVAL_W-1:0] chCount;
  logic [NUM_CH-1:0][IVAL_W-1:0] chIval;
  logic [NUM_CH-1:0]             chFlag;
  logic [NUM_CH-1:0]             chIen;
  logic [NUM_CH-1:0][1:0]        chMode;

  itmr_ctrl #(.NUM_CH(NUM_CH), .IVAL_W(IVAL_W)) u_ctrl (
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .chCount  (chCount),
    .chIval   (chIval),
    .chFlag   (chFlag),
    .chIen    (chIen),
    .chMode   (chMode),
    .strobes  (strobes),
    .wrVal    (wrVal),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  itmr_datapath #(.NUM_CH(NUM_CH), .IVAL_W(IVAL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrVal   (wrVal),
    .chCount (chCount),
    .chIval  (chIval),
    .chFlag  (chFlag),
    .chIen   (chIen),
    .chMode  (chMode)
  );

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker
  import itmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IVAL_W = 31
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          irqOut,
  input chStrobe_t [NUM_CH-1:0]        strobes,
  input logic [NUM_CH-1:0][IVAL_W-1:0] chCount,
  input logic [NUM_CH-1:0]             chFlag,
  input logic [NUM_CH-1:0]             chIen,
  input logic [NUM_CH-1:0][1:0]        chMode
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5: a running count steps down by one when untouched by the bus
    a_r5_countdown: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[c].wrIval && chCount[c] > IVAL_W'(1))
      |=> chCount[c] == $past(chCount[c]) - IVAL_W'(1));

    // R6: expiry raises the flag
    a_r6_expiry_flag: assert property (@(posedge clk) disable iff (!rstN)
      chCount[c] == IVAL_W'(1) |=> chFlag[c]);

    // R7: one-shot channel stops at expiry
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
      (chCount[c] == IVAL_W'(1) && chMode[c] == MODE_ONESHOT && !strobes[c].wrIval)
      |=> chCount[c] == '0);

    // R9: an idle channel stays idle without an interval write
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      (chCount[c] == '0 && !strobes[c].wrIval) |=> chCount[c] == '0);

    // R13: set beats clear on the same edge
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (chCount[c] == IVAL_W'(1) && strobes[c].clrFlag) |=> chFlag[c]);

    // R12: an enabled pending flag drives the interrupt
    a_r12_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
      (chFlag[c] && chIen[c]) |-> irqOut);
  end

endmodule

bind interval_timer_bank itmr_checker #(.NUM_CH(NUM_CH), .IVAL_W(IVAL_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqOut  (irqOut),
  .strobes (strobes),
  .chCount (chCount),
  .chFlag  (chFlag),
  .chIen   (chIen),
  .chMode  (chMode)
);

// File: tb/sim_interval_timer_bank.sv
module sim_interval_timer_bank;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  always #2 clk = ~clk;

  interval_timer_bank u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  int    vecs = 0;
  int    errs = 0;
  bit    finished = 0;
  string tag = "R1";
  int    rdPtr = 0;

  int unsigned mCnt [NCH];
  int unsigned mIval[NCH];
  bit          mFlag[NCH];
  bit          mIen [NCH];
  bit [1:0]    mMode[NCH];

  function automatic logic [31:0] modelRead(logic [7:0] a);
    int ch;
    int idle;
    logic [31:0] r;
    if (a < 8'h40) begin
      ch = int'(a[5:4]);
      case (a[3:2])
        2'd0: return mIval[ch];
        2'd1: return mCnt[ch];
        2'd2: return {29'b0, mMode[ch], mIen[ch]};
        default: return {30'b0, mCnt[ch] != 0, mFlag[ch]};
      endcase
    end
    if (a == 8'hF4) begin
      idle = NCH;
      for (int i = NCH - 1; i >= 0; i--) if (mCnt[i] == 0) idle = i;
      return 32'(idle) << 4;
    end
    if (a == 8'hF8) begin
      r = '0;
      for (int i = 0; i < NCH; i++) r[i] = mFlag[i];
      return r;
    end
    return '0;
  endfunction

  function automatic bit modelIrq();
    bit v = 0;
    for (int i = 0; i < NCH; i++) v |= mFlag[i] & mIen[i];
    return v;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NCH; i++) begin
      mCnt[i] = 0; mIval[i] = 0; mFlag[i] = 0; mIen[i] = 0; mMode[i] = 0;
    end
  endtask

  task automatic modelStep();
    for (int ch = 0; ch < NCH; ch++) begin
      bit hit, wrI, wrC, clr, expire, take;
      int unsigned nv, nc;
      hit    = busWe && busAddr[7:6] == 2'b00 && int'(busAddr[5:4]) == ch;
      wrI    = hit && busAddr[3:2] == 2'd0;
      wrC    = hit && busAddr[3:2] == 2'd2;
      clr    = (hit && busAddr[3:2] == 2'd3 && busWdata[0])
             || (busWe && busAddr == 8'hF8 && busWdata[ch]);
      nv     = busWdata & 32'h7FFF_FFFF;
      expire = mCnt[ch] == 1;
      take   = wrI && (busWdata[31] || mCnt[ch] == 0);
      if (take)             nc = nv;
      else if (expire)      nc = (mMode[ch] == 2'd1) ? 0 : mIval[ch];
      else if (mCnt[ch] != 0) nc = mCnt[ch] - 1;
      else                  nc = 0;
      mCnt[ch] = nc;
      if (expire)   mFlag[ch] = 1;
      else if (clr) mFlag[ch] = 0;
      if (wrI) mIval[ch] = nv;
      if (wrC) begin mIen[ch] = busWdata[0]; mMode[ch] = busWdata[2:1]; end
    end
  endtask

  task automatic compare();
    logic [31:0] exp;
    bit expIrq;
    exp = modelRead(busAddr);
    vecs++;
    if (busRdata !== exp) begin
      errs++;
      $display("FAIL %s addr %h rdata actual %h expected %h", tag, busAddr, busRdata, exp);
    end
    expIrq = modelIrq();
    vecs++;
    if (irqOut !== expIrq) begin
      errs++;
      $display("FAIL %s/R12 irqOut actual %0b expected %0b", tag, irqOut, expIrq);
    end
  endtask

  task automatic cycle(logic [7:0] a, bit we, logic [31:0] wd);
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = wd;
    #1 compare();
    @(posedge clk);
    if (rstN) modelStep(); else modelReset();
  endtask

  function automatic logic [7:0] readAddr(int p);
    int k = p % 21;
    if (k < 16) return 8'(k * 4);
    case (k)
      16: return 8'hF0;
      17: return 8'hF4;
      18: return 8'hF8;
      19: return 8'hFC;
      default: return 8'h40;
    endcase
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      cycle(readAddr(rdPtr), 0, 32'h0);
      rdPtr++;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cycle(a, 1, d);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    modelReset();
    // R1: reset state on every address
    tag = "R1";
    idle(22);
    @(negedge clk); rstN = 1'b1;
    idle(21);

    // R8: control read-back, modes 0..3
    tag = "R8";
    wr(8'h08, 32'hFFFF_FFF9);     // enable, repeat
    wr(8'h18, 32'h0000_0003);     // enable, one-shot
    wr(8'h28, 32'h0000_0000);     // disabled, repeat
    wr(8'h38, 32'h0000_0005);     // enable, mode 2 (repeats)
    idle(8);

    // R3: immediate load, repeat reload
    tag = "R3";
    wr(8'h00, 32'h8000_0005);
    idle(20);

    // R7 one-shot via deferred write to idle channel (R4 idle case)
    tag = "R7";
    wr(8'h10, 32'h0000_0007);
    idle(14);

    // R4: deferred interval change on running channel
    tag = "R4";
    wr(8'h20, 32'h8000_0006);
    idle(2);
    wr(8'h20, 32'h0000_000A);
    idle(30);

    // R5: timer register writes ignored
    tag = "R5";
    wr(8'h04, 32'h8000_0100);
    wr(8'h24, 32'h0000_0001);
    idle(6);

    // R9: zero loads stop / keep idle
    tag = "R9";
    wr(8'h00, 32'h8000_0000);
    wr(8'h10, 32'h0000_0000);
    idle(6);

    // R13: clears applied every cycle while channels expire
    tag = "R13";
    wr(8'h30, 32'h8000_0003);
    for (int i = 0; i < 12; i++) wr(8'hF8, 32'h0000_000F);
    for (int i = 0; i < 8; i++)  wr(8'h3C, 32'h0000_0001);
    idle(4);

    // R10: all channels busy, then one freed
    tag = "R10";
    wr(8'h00, 32'h8000_0032);
    wr(8'h10, 32'h8000_0032);
    wr(8'h20, 32'h8000_0032);
    wr(8'h30, 32'h8000_0032);
    for (int i = 0; i < 4; i++) cycle(8'hF4, 0, 0);
    wr(8'h10, 32'h8000_0000);
    cycle(8'hF4, 0, 0);
    cycle(8'hF4, 0, 0);

    // R2: largest interval, read of each window
    tag = "R2";
    wr(8'h00, 32'hFFFF_FFFF);
    idle(25);

    // R11: partial mask clear and status clear
    tag = "R11";
    wr(8'h20, 32'h8000_0002);
    wr(8'h30, 32'h8000_0002);
    idle(3);
    wr(8'h28, 32'h0000_0001);
    wr(8'h38, 32'h0000_0001);
    idle(2);
    wr(8'hF8, 32'h0000_0005);
    idle(3);
    wr(8'h2C, 32'h0000_0001);
    idle(3);

    // R6 / R12: mixed random traffic
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int unsigned pick = $urandom % 10;
      int unsigned ch   = $urandom % NCH;
      logic [7:0] base  = 8'(ch * 16);
      case (pick)
        0, 1: wr(base, {1'($urandom), 31'($urandom % 24)});
        2:    wr(base + 8'h08, 32'($urandom % 8));
        3:    wr(base + 8'h0C, 32'($urandom));
        4:    wr(8'hF8, 32'($urandom));
        5:    wr(base + 8'h04, 32'($urandom));
        default: idle(1);
      endcase
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule